// File: doc/BRIEF.md
# Branch and Skip Decision Unit

This block settles, for one conditional control-flow instruction at a time, whether the instruction changes the flow and what the next program counter is. It covers two kinds of instruction. A relative branch tests one selectable status bit, either for 1 or for 0, and adds a signed 7-bit word offset. A skip tests one I/O bit and steps over the next instruction. The block also reports how many cycles the instruction takes. Every named branch condition maps onto the one generic test. For example, "same or higher" is a clear test on carry, and "lower" is a set test on carry. The signed comparisons use selector 4, whose value is recomputed as N xor V.

A request is given on one clock edge with `req_valid` high. The decision appears on the registered outputs one cycle later, marked by `rsp_valid`. A new request can be given on every cycle. Instruction fetch, full opcode decode and the I/O register file sit outside the block. No status flag is ever written: the status byte is only an input.

Top module: `bsd_unit`

## Requirements
- R1: After reset, `rsp_valid`, `taken`, `next_pc` and `cycles` are all 0.
- R2: The status bit order, MSB to LSB, is I, T, H, S, V, N, Z, C, so C is bit 0. With `op` = 2'b00 (branch-if-set), the result is taken exactly when the bit chosen by `flag_sel` is 1.
- R3: With `op` = 2'b01 (branch-if-clear), the result is taken exactly when the chosen bit is 0.
- R4: When `flag_sel` = 4, the tested value is status bit 2 (N) xor status bit 3 (V). The stored bit 4 is ignored.
- R5: For a taken branch, `next_pc` = pc + sign-extended offset + 1. For a branch that is not taken, `next_pc` = pc + 1. Both wrap modulo 2^PC_W.
- R6: A branch reports `cycles` = 2 when taken and 1 when not taken.
- R7: With `op` = 2'b10 (skip-if-bit-set), the result is taken exactly when `io_bit` is 1. A taken skip gives `next_pc` = pc + 3 if `next_two_word` is 1, and pc + 2 otherwise. A skip that is not taken gives pc + 1.
- R8: A skip reports `cycles` = 1 when not taken, 2 when it steps over a one-word instruction, and 3 when it steps over a two-word instruction.
- R9: With `op` = 2'b11 (reserved), the result is not taken, `next_pc` = pc + 1 and `cycles` = 1.
- R10: `rsp_valid` is high in exactly the cycle after each cycle with `req_valid` high. In a cycle without a request, `next_pc`, `taken` and `cycles` hold their previous values.
- R11: A branch ignores `io_bit` and `next_two_word`. A skip ignores `status`, `flag_sel` and `offset`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| op | input | 2 | 00 branch-if-set, 01 branch-if-clear, 10 skip-if-bit-set, 11 reserved |
| status | input | 8 | Status byte {I,T,H,S,V,N,Z,C} |
| flag_sel | input | 3 | Index of the status bit tested by a branch |
| offset | input | 7 | Signed word offset of a branch |
| pc | input | PC_W | Word address of the current instruction |
| io_bit | input | 1 | Value of the I/O bit tested by a skip |
| next_two_word | input | 1 | The instruction after this one is two words long |
| rsp_valid | output | 1 | Result valid |
| taken | output | 1 | Branch taken or skip performed |
| next_pc | output | PC_W | Word address of the next instruction |
| cycles | output | 2 | Cycle count of the instruction |

## Verification
The bench gives requests on every cycle, so a new request is accepted in the same cycle that the previous result is presented. Each result must therefore match its own request and must not be mixed with the next one. The second overlap is the wrap of the offset adder and the signed-flag recomputation. Directed cases put a taken branch at the top and the bottom of the address space. Other directed cases set selector 4 with a stored S bit that disagrees with N xor V. Bench functions compute the expected values from the requirements and compare them in the sampling cycle after each request.

// File: rtl/bsd_pkg.sv
package bsd_pkg;
  typedef enum logic [1:0] {
    OP_BSET = 2'b00,
    OP_BCLR = 2'b01,
    OP_SKIP = 2'b10,
    OP_RSV  = 2'b11
  } op_e;

  localparam int SR_W     = 8;
  localparam int SEL_W    = 3;
  localparam int OFF_W    = 7;
  localparam int CYC_W    = 2;
  // status byte positions used by the signed test
  localparam int SIGN_IDX = 4;
  localparam int OVF_IDX  = 3;
  localparam int NEG_IDX  = 2;
endpackage

// File: rtl/bsd_flag_pick.sv
module bsd_flag_pick
  import bsd_pkg::*;
#(
  parameter int W   = SR_W,
  parameter int S_W = SEL_W
) (
  input  logic [W-1:0]   status,
  input  logic [S_W-1:0] sel,
  output logic           flag_bit,
  output logic           sign_path
);
  logic [W-1:0] eff;

  // rebuild the sign position from N and V; every other bit passes through
  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (i == SIGN_IDX) begin : g_sign
        assign eff[i] = status[NEG_IDX] ^ status[OVF_IDX];
      end else begin : g_plain
        assign eff[i] = status[i];
      end
    end
  endgenerate

  assign sign_path = (int'(sel) == SIGN_IDX);
  assign flag_bit  = eff[sel];
endmodule

// File: rtl/bsd_next_pc.sv
module bsd_next_pc
  import bsd_pkg::*;
#(
  parameter int PC_W = 16,
  parameter int O_W  = OFF_W
) (
  input  logic [1:0]       op,
  input  logic             flag_bit,
  input  logic             io_bit,
  input  logic             two_word,
  input  logic [PC_W-1:0]  pc,
  input  logic [O_W-1:0]   offset,
  output logic [PC_W-1:0]  nxt,
  output logic             taken,
  output logic [CYC_W-1:0] cycles
);
  function automatic logic [PC_W-1:0] sext(input logic [O_W-1:0] k);
    return {{(PC_W-O_W){k[O_W-1]}}, k};
  endfunction

  function automatic logic [PC_W-1:0] step(input logic [PC_W-1:0] base, input int unsigned n);
    return base + PC_W'(n);
  endfunction

  op_e o;
  assign o = op_e'(op);

  always_comb begin
    taken  = 1'b0;
    nxt    = step(pc, 1);
    cycles = CYC_W'(1);
    case (o)
      OP_BSET, OP_BCLR: begin
        taken = (o == OP_BSET) ? flag_bit : ~flag_bit;
        if (taken) begin
          nxt    = step(pc + sext(offset), 1);
          cycles = CYC_W'(2);
        end
      end
      OP_SKIP: begin
        taken = io_bit;
        if (taken) begin
          nxt    = step(pc, two_word ? 3 : 2);
          cycles = CYC_W'(two_word ? 3 : 2);
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bsd_unit.sv
module bsd_unit
  import bsd_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        op,
  input  logic [7:0]        status,
  input  logic [2:0]        flag_sel,
  input  logic [6:0]        offset,
  input  logic [PC_W-1:0]   pc,
  input  logic              io_bit,
  input  logic              next_two_word,
  output logic              rsp_valid,
  output logic              taken,
  output logic [PC_W-1:0]   next_pc,
  output logic [1:0]        cycles
);
  logic             flag_bit, sign_path;
  logic             taken_d;
  logic [PC_W-1:0]  nxt_d;
  logic [CYC_W-1:0] cyc_d;
  logic [1:0]       op_q;

  bsd_flag_pick #(.W(SR_W), .S_W(SEL_W)) u_pick (
    .status(status), .sel(flag_sel), .flag_bit(flag_bit), .sign_path(sign_path)
  );

  bsd_next_pc #(.PC_W(PC_W), .O_W(OFF_W)) u_npc (
    .op(op), .flag_bit(flag_bit), .io_bit(io_bit), .two_word(next_two_word),
    .pc(pc), .offset(offset), .nxt(nxt_d), .taken(taken_d), .cycles(cyc_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      taken     <= 1'b0;
      next_pc   <= '0;
      cycles    <= '0;
      op_q      <= OP_RSV;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        taken   <= taken_d;
        next_pc <= nxt_d;
        cycles  <= cyc_d;
        op_q    <= op;
      end
    end
  end

  a_r10_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r10_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && $stable(next_pc) && $stable(taken));
  a_r6_branch_cycles: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !op_q[1]) |-> cycles == (taken ? 2'd2 : 2'd1));
  a_r8_skip_cycles: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && op_q == OP_SKIP) |-> (taken ? cycles != 2'd1 : cycles == 2'd1));
  a_r9_reserved_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && op_q == OP_RSV) |-> !taken && cycles == 2'd1);
  a_r7_skip_distance: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op == OP_SKIP && io_bit) |=>
      next_pc == $past(pc) + ($past(next_two_word) ? PC_W'(3) : PC_W'(2)));
  a_r4_signed_test: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && sign_path && op == OP_BSET) |=>
      taken == ($past(status[NEG_IDX]) ^ $past(status[OVF_IDX])));
endmodule

// File: tb/bsd_unit_test.sv
module bsd_unit_test;
  localparam int PC_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] op = 2'b00;
  logic [7:0] status = 8'h00;
  logic [2:0] flag_sel = 3'd0;
  logic [6:0] offset = 7'd0;
  logic [PC_W-1:0] pc = '0;
  logic io_bit = 1'b0;
  logic next_two_word = 1'b0;
  logic rsp_valid, taken;
  logic [PC_W-1:0] next_pc;
  logic [1:0] cycles;

  int total = 0;
  int bad = 0;
  bit pend = 0;
  string pend_tag;
  logic e_tk;
  logic [PC_W-1:0] e_pc;
  logic [1:0] e_cy;

  always #5 clk = ~clk;

  bsd_unit #(.PC_W(PC_W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op(op), .status(status),
    .flag_sel(flag_sel), .offset(offset), .pc(pc), .io_bit(io_bit),
    .next_two_word(next_two_word), .rsp_valid(rsp_valid), .taken(taken),
    .next_pc(next_pc), .cycles(cycles)
  );

  function automatic logic ref_bit(input logic [7:0] s, input logic [2:0] sel);
    if (sel == 3'd4) return s[2] ^ s[3];   // R4
    return s[sel];                         // R2
  endfunction

  function automatic logic ref_taken(input logic [1:0] o, input logic [7:0] s,
                                     input logic [2:0] sel, input logic iob);
    case (o)
      2'b00: return ref_bit(s, sel);       // R2
      2'b01: return !ref_bit(s, sel);      // R3
      2'b10: return iob;                   // R7
      default: return 1'b0;                // R9
    endcase
  endfunction

  function automatic logic [PC_W-1:0] ref_pc(input logic [1:0] o, input logic tk,
      input logic [PC_W-1:0] p, input logic [6:0] k, input logic tw);
    int signed kk;
    kk = (k >= 7'd64) ? int'(k) - 128 : int'(k);
    if (!tk) return p + 1;
    if (o == 2'b10) return tw ? p + 3 : p + 2;       // R7
    return PC_W'(int'(p) + kk + 1);                  // R5
  endfunction

  function automatic logic [1:0] ref_cyc(input logic [1:0] o, input logic tk, input logic tw);
    if (!tk) return 2'd1;
    if (o == 2'b10) return tw ? 2'd3 : 2'd2;         // R8
    return 2'd2;                                     // R6
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_pending();
    if (pend) begin
      check({pend_tag, " rsp_valid R10"}, 32'(rsp_valid), 32'd1);
      check({pend_tag, " taken"}, 32'(taken), 32'(e_tk));
      check({pend_tag, " next_pc"}, 32'(next_pc), 32'(e_pc));
      check({pend_tag, " cycles"}, 32'(cycles), 32'(e_cy));
      pend = 0;
    end
  endtask

  task automatic req(input string tag, input logic [1:0] o, input logic [7:0] s,
      input logic [2:0] sel, input logic [6:0] k, input logic [PC_W-1:0] p,
      input logic iob, input logic tw);
    @(negedge clk);
    check_pending();
    req_valid = 1'b1; op = o; status = s; flag_sel = sel; offset = k;
    pc = p; io_bit = iob; next_two_word = tw;
    e_tk = ref_taken(o, s, sel, iob);
    e_pc = ref_pc(o, e_tk, p, k, tw);
    e_cy = ref_cyc(o, e_tk, tw);
    pend_tag = tag;
    pend = 1;
  endtask

  task automatic idle();
    @(negedge clk);
    check_pending();
    req_valid = 1'b0;
    op = 2'($urandom); pc = PC_W'($urandom);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [PC_W-1:0] held;
    void'($urandom(32'd7331));
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1 rsp_valid", 32'(rsp_valid), 0);
    check("R1 taken", 32'(taken), 0);
    check("R1 next_pc", 32'(next_pc), 0);
    check("R1 cycles", 32'(cycles), 0);
    rst_n = 1'b1;

    // directed corner cases, back to back
    req("R2 carry set taken", 2'b00, 8'h01, 3'd0, 7'd5, 16'h0100, 1'b0, 1'b0);
    req("R3 same-or-higher", 2'b01, 8'h01, 3'd0, 7'd5, 16'h0100, 1'b1, 1'b1);
    req("R3 interrupt clear", 2'b01, 8'h7F, 3'd7, 7'h10, 16'h0200, 1'b0, 1'b0);
    req("R4 ge with stale S", 2'b01, 8'h1C, 3'd4, 7'h03, 16'h0300, 1'b0, 1'b0);
    req("R4 lt with stale S", 2'b00, 8'h08, 3'd4, 7'h7F, 16'h0300, 1'b0, 1'b0);
    req("R5 wrap low", 2'b00, 8'h02, 3'd1, 7'h40, 16'h0010, 1'b0, 1'b0);
    req("R5 wrap high", 2'b00, 8'h02, 3'd1, 7'h3F, 16'hFFF0, 1'b0, 1'b0);
    req("R6 not taken", 2'b00, 8'h00, 3'd6, 7'h3F, 16'h1234, 1'b1, 1'b1);
    req("R7 skip one word", 2'b10, 8'hFF, 3'd0, 7'h20, 16'h0400, 1'b1, 1'b0);
    req("R8 skip two word", 2'b10, 8'h00, 3'd5, 7'h11, 16'hFFFE, 1'b1, 1'b1);
    req("R11 skip not taken", 2'b10, 8'hFF, 3'd1, 7'h7F, 16'h0500, 1'b0, 1'b1);
    req("R9 reserved", 2'b11, 8'hFF, 3'd0, 7'h3F, 16'h0600, 1'b1, 1'b1);
    idle();
    held = next_pc;
    @(negedge clk);
    check("R10 no rsp when idle", 32'(rsp_valid), 0);
    check("R10 next_pc holds", 32'(next_pc), 32'(held));

    // constrained random, back to back
    for (int i = 0; i < 600; i++) begin
      logic [1:0] o;
      o = ((i % 8) == 7) ? 2'b11 : 2'($urandom % 3);
      req($sformatf("R11 rand%0d op%0d", i, o), o, 8'($urandom), 3'($urandom),
          7'($urandom), PC_W'($urandom), 1'($urandom), 1'($urandom));
      if ((i % 37) == 0) idle();
    end
    idle();
    @(negedge clk);
    check("R10 final idle", 32'(rsp_valid), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule